// File: doc/BRIEF.md
# Multi-Pipe Buffer Port Selector

This block is the CPU-facing access port of a packet buffer memory that is divided into one region per logical pipe. Pipe 0 is the control pipe; pipes 1 to 7 carry data. Software writes a select register to choose the pipe the port serves, whether to restart it from its first byte, the access width, and, for the control pipe only, the transfer direction. Each pipe keeps its own byte pointer, so software can leave a transfer half done, serve another pipe, and later come back to the same byte.

A registered ready flag tells software when the selected buffer may be read or written. Data-register reads and writes become byte or halfword accesses on a simple memory interface, and each one moves the pipe's pointer forward. When the serial engine still owns a buffer that software wants to read, a toggle write can hand the buffer to the CPU side. A successful hand-over raises a one-cycle buffer-ready interrupt bit for that pipe. A parameter builds the same block as a DMA-side port, which cannot serve the control pipe.

Top module: `pipe_port_sel`

## Requirements
- R1: A select write (`sel_we`=1) makes `sel_pipe` the current pipe. Accesses then address that pipe's region: `mem_addr` = pipe*64 + pointer, and `rd_data` returns the byte at `mem_addr` in bits 7:0 and the byte at `mem_addr`+1 in bits 15:8.
- R2: In the cycle after a select write, `rdy` is 0. From the following cycle, `rdy` is the registered value of (selection allowed and (`buf_avail` of the current pipe is 1 or the pipe was handed over)). Data accesses are refused in a select cycle and whenever `rdy` is 0. A refused access gives no `mem_re`/`mem_we` and does not move the pointer.
- R3: A select write with `sel_rewind`=1 sets the chosen pipe's pointer to 0.
- R4: A select write with `sel_rewind`=0 keeps the chosen pipe's saved pointer. Every pipe keeps its pointer while other pipes are in use.
- R5: `sel_wide`=0 selects byte access: `mem_be`=01, `rd_data`={8'h00, byte}, `mem_wdata`={8'h00, `wr_data`[7:0]}, and the pointer moves by 1. `sel_wide`=1 selects halfword access: `mem_be`=11 and the pointer moves by 2. Pointers wrap modulo 64.
- R6: For pipes 1 to 7 the direction is `cfg_dir[pipe]`; for pipe 0 it is the `sel_dir` value latched at selection. The encoding is 1 = write into the buffer and 0 = read. Only `rd_en` on a read pipe or `wr_en` on a write pipe is accepted; the other is ignored.
- R7: With `DMA_PORT`=1, selecting pipe 0 never raises `rdy` and never produces a memory access. Pipes 1 to 7 behave as on the CPU port.
- R8: A toggle write (`tgl_we`=1) hands the current pipe over to the CPU when all of these hold: no select write in the same cycle, the selection is allowed, `rdy`=0, the direction is read, and `sbusy`=0. `rdy` then rises one cycle after the interrupt pulse. The hand-over lasts until that pipe is selected again.
- R9: A successful toggle sets the current pipe's bit of `brdy_irq` (bit p for pipe p) for exactly one cycle, in the cycle after the toggle write.
- R10: A toggle write is ignored, with no interrupt and no hand-over, in any of these cases: `sbusy`=1, the pipe is in write direction, `rdy`=1, or a select write happens in the same cycle.
- R11: After reset: `rdy`=0, `brdy_irq`=0, the current pipe is 0 in read direction with byte width, and all pointers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe of the select register |
| sel_pipe | input | 3 | Pipe to select |
| sel_rewind | input | 1 | Restart the selected pipe at byte 0 |
| sel_wide | input | 1 | Access width: 0 byte, 1 halfword |
| sel_dir | input | 1 | Control pipe direction: 1 write, 0 read |
| cfg_dir | input | 8 | Per-pipe direction for pipes 1..7 (1 write) |
| buf_avail | input | 8 | Per-pipe buffer accessible to the CPU side |
| sbusy | input | 1 | Serial engine busy on the current pipe |
| tgl_we | input | 1 | Toggle write requesting hand-over |
| rd_en | input | 1 | Data register read |
| wr_en | input | 1 | Data register write |
| wr_data | input | 16 | Data register write value |
| rd_data | output | 16 | Data register read value |
| rdy | output | 1 | Port ready |
| brdy_irq | output | 8 | One-cycle buffer-ready interrupt per pipe |
| mem_addr | output | 9 | Buffer memory byte address |
| mem_re | output | 1 | Buffer memory read strobe |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_be | output | 2 | Buffer memory byte enables |
| mem_wdata | output | 16 | Buffer memory write data |
| mem_rdata | input | 16 | Buffer memory read data (combinational) |

## Verification
The properties assume that the memory answers combinationally on the address the block presents. They also assume that software has already set the pipe response to NAK before a toggle write. That second condition lives outside this block, so the block only sees `sbusy`. The stimulus keeps `mem_rdata` a pure function of `mem_addr`. It issues toggle writes freely, with `sbusy` held high or low, so both the refused and the accepted hand-over paths occur. Select writes, accesses and changes to `buf_avail` appear in any combination, including accesses during the ready gap and accesses against the pipe's direction.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic { DIR_RD = 1'b0, DIR_WR = 1'b1 } pps_dir_e;
  typedef enum logic { WID_BYTE = 1'b0, WID_HALF = 1'b1 } pps_wid_e;

  function automatic logic [1:0] pps_step(pps_wid_e w);
    return (w == WID_HALF) ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/pps_ptr_bank.sv
module pps_ptr_bank #(
  parameter int NPIPE    = 8,
  parameter int REGION_W = 6,
  localparam int PIPE_W  = $clog2(NPIPE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [PIPE_W-1:0]   clr_idx,
  input  logic                adv,
  input  logic [PIPE_W-1:0]   idx,
  input  logic [1:0]          step,
  output logic [REGION_W-1:0] cur_ptr
);
  logic [REGION_W-1:0] ptr_q [NPIPE];
  logic [REGION_W-1:0] ptr_n [NPIPE];

  for (genvar g = 0; g < NPIPE; g++) begin : g_ptr
    always_comb begin
      ptr_n[g] = ptr_q[g];
      if (clr && (clr_idx == PIPE_W'(g)))
        ptr_n[g] = '0;
      else if (adv && (idx == PIPE_W'(g)))
        ptr_n[g] = ptr_q[g] + REGION_W'(step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[g] <= '0;
      else        ptr_q[g] <= ptr_n[g];
    end
  end

  assign cur_ptr = ptr_q[idx];
endmodule

// File: rtl/pps_rdy_ctl.sv
module pps_rdy_ctl #(
  parameter int NPIPE   = 8,
  localparam int PIPE_W = $clog2(NPIPE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [PIPE_W-1:0] sel_idx,
  input  logic [PIPE_W-1:0] cur,
  input  logic              valid,
  input  logic              dir_wr,
  input  logic [NPIPE-1:0]  buf_avail,
  input  logic              tgl_we,
  input  logic              sbusy,
  output logic              rdy,
  output logic [NPIPE-1:0]  brdy_irq
);
  logic [NPIPE-1:0] force_q, force_n;
  logic [NPIPE-1:0] irq_q, irq_n;
  logic             rdy_q, rdy_n;
  logic             tgl_ok;

  always_comb begin
    tgl_ok  = tgl_we && !sel_we && valid && !rdy_q && !dir_wr && !sbusy;
    rdy_n   = !sel_we && valid && (buf_avail[cur] || force_q[cur]);
    force_n = force_q;
    irq_n   = '0;
    if (tgl_ok) begin
      force_n[cur] = 1'b1;
      irq_n[cur]   = 1'b1;
    end
    if (sel_we) force_n[sel_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= '0;
      irq_q   <= '0;
      rdy_q   <= 1'b0;
    end else begin
      force_q <= force_n;
      irq_q   <= irq_n;
      rdy_q   <= rdy_n;
    end
  end

  assign rdy      = rdy_q;
  assign brdy_irq = irq_q;
endmodule

// File: rtl/pipe_port_sel.sv
module pipe_port_sel
  import pps_pkg::*;
#(
  parameter int NPIPE    = 8,
  parameter int REGION_W = 6,
  parameter int DMA_PORT = 0,
  localparam int PIPE_W  = $clog2(NPIPE),
  localparam int ADDR_W  = PIPE_W + REGION_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [PIPE_W-1:0] sel_pipe,
  input  logic              sel_rewind,
  input  logic              sel_wide,
  input  logic              sel_dir,
  input  logic [NPIPE-1:0]  cfg_dir,
  input  logic [NPIPE-1:0]  buf_avail,
  input  logic              sbusy,
  input  logic              tgl_we,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              rdy,
  output logic [NPIPE-1:0]  brdy_irq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  localparam logic CTL_ALLOWED = (DMA_PORT == 0);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // select register
  logic [PIPE_W-1:0] cur_q, cur_n;
  logic              valid_q, valid_n;
  pps_wid_e          wid_q, wid_n;
  pps_dir_e          cdir_q, cdir_n;

  always_comb begin
    cur_n   = cur_q;
    valid_n = valid_q;
    wid_n   = wid_q;
    cdir_n  = cdir_q;
    if (sel_we) begin
      cur_n   = sel_pipe;
      valid_n = (sel_pipe != '0) || CTL_ALLOWED;
      wid_n   = pps_wid_e'(sel_wide);
      cdir_n  = pps_dir_e'(sel_dir);
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cur_q   <= '0;
      valid_q <= CTL_ALLOWED;
      wid_q   <= WID_BYTE;
      cdir_q  <= DIR_RD;
    end else begin
      cur_q   <= cur_n;
      valid_q <= valid_n;
      wid_q   <= wid_n;
      cdir_q  <= cdir_n;
    end
  end

  // direction and access decode
  pps_dir_e eff_dir;
  logic     acc_rd, acc_wr;
  logic     dir_wr;

  always_comb begin
    eff_dir = (cur_q == '0) ? cdir_q : pps_dir_e'(cfg_dir[cur_q]);
    dir_wr  = (eff_dir == DIR_WR);
    acc_rd  = rdy && !sel_we && rd_en && !dir_wr;
    acc_wr  = rdy && !sel_we && wr_en &&  dir_wr;
  end

  logic [REGION_W-1:0] cur_ptr;

  pps_ptr_bank #(.NPIPE(NPIPE), .REGION_W(REGION_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (sel_we && sel_rewind),
    .clr_idx (sel_pipe),
    .adv     (acc_rd || acc_wr),
    .idx     (cur_q),
    .step    (pps_step(wid_q)),
    .cur_ptr (cur_ptr)
  );

  pps_rdy_ctl #(.NPIPE(NPIPE)) u_rdy (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .sel_we    (sel_we),
    .sel_idx   (sel_pipe),
    .cur       (cur_q),
    .valid     (valid_q),
    .dir_wr    (dir_wr),
    .buf_avail (buf_avail),
    .tgl_we    (tgl_we),
    .sbusy     (sbusy),
    .rdy       (rdy),
    .brdy_irq  (brdy_irq)
  );

  // memory side
  always_comb begin
    mem_addr = {cur_q, cur_ptr};
    mem_re   = acc_rd;
    mem_we   = acc_wr;
    if (wid_q == WID_HALF) begin
      mem_be    = 2'b11;
      mem_wdata = wr_data;
      rd_data   = mem_rdata;
    end else begin
      mem_be    = 2'b01;
      mem_wdata = {8'h00, wr_data[7:0]};
      rd_data   = {8'h00, mem_rdata[7:0]};
    end
  end
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int NPIPE    = 8,
  parameter int REGION_W = 6,
  parameter int DMA_PORT = 0,
  localparam int PIPE_W  = $clog2(NPIPE),
  localparam int ADDR_W  = PIPE_W + REGION_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_we,
  input logic [PIPE_W-1:0] sel_pipe,
  input logic              sel_rewind,
  input logic              sbusy,
  input logic              tgl_we,
  input logic              rd_en,
  input logic              wr_en,
  input logic              rdy,
  input logic [NPIPE-1:0]  brdy_irq,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_re,
  input logic              mem_we,
  input logic [1:0]        mem_be
);
  logic [REGION_W-1:0] nxt_off;
  assign nxt_off = mem_addr[REGION_W-1:0] +
                   ((mem_be == 2'b11) ? REGION_W'(2) : REGION_W'(1));

  // R1: the selected pipe's region is addressed after a select
  p_sel_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> mem_addr[ADDR_W-1:REGION_W] == $past(sel_pipe));

  // R2: ready gap after a select write
  p_rdy_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> !rdy);

  // R2: memory touched only while ready and outside a select cycle
  p_no_access_unready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> (rdy && !sel_we));

  // R3: rewind lands at byte 0 of the chosen region
  p_rewind_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_rewind) |=> mem_addr[REGION_W-1:0] == '0);

  // R5: pointer step follows the access width
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |=> (mem_addr[REGION_W-1:0] == $past(nxt_off)) &&
                           $stable(mem_addr[ADDR_W-1:REGION_W]));

  // R6: strobes follow the matching request, never both
  p_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re |-> rd_en) and (mem_we |-> wr_en) and !(mem_re && mem_we));

  // R9: at most one interrupt bit, only right after a toggle write
  p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(brdy_irq));
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brdy_irq != '0) |-> $past(tgl_we));

  // R10: refused toggles
  p_tgl_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_we && (sbusy || rdy || sel_we)) |=> brdy_irq == '0);

  if (DMA_PORT != 0) begin : g_dma
    // R7: a DMA-side port never touches the control pipe region
    p_dma_ctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re || mem_we) |-> mem_addr[ADDR_W-1:REGION_W] != '0);
  end
endmodule

bind pipe_port_sel pps_checker #(
  .NPIPE(NPIPE), .REGION_W(REGION_W), .DMA_PORT(DMA_PORT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_we     (sel_we),
  .sel_pipe   (sel_pipe),
  .sel_rewind (sel_rewind),
  .sbusy      (sbusy),
  .tgl_we     (tgl_we),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .rdy        (rdy),
  .brdy_irq   (brdy_irq),
  .mem_addr   (mem_addr),
  .mem_re     (mem_re),
  .mem_we     (mem_we),
  .mem_be     (mem_be)
);

// File: tb/sim_pipe_port_sel.sv
`timescale 1ns/1ps
module sim_pipe_port_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_we, sel_rewind, sel_wide, sel_dir;
  logic [2:0]  sel_pipe;
  logic [7:0]  cfg_dir, buf_avail;
  logic        sbusy, tgl_we, rd_en, wr_en;
  logic [15:0] wr_data;

  logic [15:0] u0_rd_data, u0_wdata, u0_rdata;
  logic        u0_rdy, u0_re, u0_we;
  logic [7:0]  u0_irq;
  logic [8:0]  u0_addr;
  logic [1:0]  u0_be;

  logic [15:0] u1_rd_data, u1_wdata;
  logic        u1_rdy, u1_re, u1_we;
  logic [7:0]  u1_irq;
  logic [8:0]  u1_addr;
  logic [1:0]  u1_be;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat8(logic [8:0] a);
    return 8'((a * 7) + 3);
  endfunction

  assign u0_rdata = {pat8(u0_addr + 9'd1), pat8(u0_addr)};

  pipe_port_sel #(.NPIPE(8), .REGION_W(6), .DMA_PORT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_pipe(sel_pipe),
    .sel_rewind(sel_rewind), .sel_wide(sel_wide), .sel_dir(sel_dir),
    .cfg_dir(cfg_dir), .buf_avail(buf_avail), .sbusy(sbusy), .tgl_we(tgl_we),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(u0_rd_data),
    .rdy(u0_rdy), .brdy_irq(u0_irq), .mem_addr(u0_addr), .mem_re(u0_re),
    .mem_we(u0_we), .mem_be(u0_be), .mem_wdata(u0_wdata), .mem_rdata(u0_rdata)
  );

  pipe_port_sel #(.NPIPE(8), .REGION_W(6), .DMA_PORT(1)) u1 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_pipe(sel_pipe),
    .sel_rewind(sel_rewind), .sel_wide(sel_wide), .sel_dir(sel_dir),
    .cfg_dir(cfg_dir), .buf_avail(buf_avail), .sbusy(sbusy), .tgl_we(tgl_we),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(u1_rd_data),
    .rdy(u1_rdy), .brdy_irq(u1_irq), .mem_addr(u1_addr), .mem_re(u1_re),
    .mem_we(u1_we), .mem_be(u1_be), .mem_wdata(u1_wdata), .mem_rdata(16'h0000)
  );

  // behavioural reference for u0
  int   m_cur;
  int   m_ptr [8];
  bit   m_force [8];
  bit   m_rdy, m_valid, m_wide, m_cdir;
  logic [7:0] m_irq;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit m_dir_wr();
    return (m_cur == 0) ? m_cdir : cfg_dir[m_cur];
  endfunction

  function automatic int m_addr();
    return m_cur * 64 + m_ptr[m_cur];
  endfunction

  task automatic compare();
    bit          e_re, e_we;
    logic [8:0]  a;
    logic [15:0] e_rd, e_wd;
    e_re = m_rdy && !sel_we && rd_en && !m_dir_wr();
    e_we = m_rdy && !sel_we && wr_en &&  m_dir_wr();
    a    = 9'(m_addr());
    e_rd = m_wide ? {pat8(a + 9'd1), pat8(a)} : {8'h00, pat8(a)};
    e_wd = m_wide ? wr_data : {8'h00, wr_data[7:0]};
    chk(u0_rdy == m_rdy, "R2", "rdy", 32'(u0_rdy), 32'(m_rdy));
    chk(u0_addr == a, "R4", "mem_addr", 32'(u0_addr), 32'(a));
    chk(u0_re == e_re, "R6", "mem_re", 32'(u0_re), 32'(e_re));
    chk(u0_we == e_we, "R6", "mem_we", 32'(u0_we), 32'(e_we));
    chk(u0_be == (m_wide ? 2'b11 : 2'b01), "R5", "mem_be", 32'(u0_be), m_wide ? 32'd3 : 32'd1);
    chk(u0_rd_data == e_rd, "R1", "rd_data", 32'(u0_rd_data), 32'(e_rd));
    chk(u0_irq == m_irq, "R9", "brdy_irq", 32'(u0_irq), 32'(m_irq));
    if (e_we) chk(u0_wdata == e_wd, "R5", "mem_wdata", 32'(u0_wdata), 32'(e_wd));
  endtask

  task automatic model_step();
    bit acc, tgl_ok, rdy_n;
    acc    = m_rdy && !sel_we && ((rd_en && !m_dir_wr()) || (wr_en && m_dir_wr()));
    tgl_ok = tgl_we && !sel_we && m_valid && !m_rdy && !m_dir_wr() && !sbusy;
    rdy_n  = !sel_we && m_valid && (buf_avail[m_cur] || m_force[m_cur]);
    m_irq  = 8'h00;
    if (tgl_ok) begin
      m_force[m_cur] = 1'b1;
      m_irq[m_cur]   = 1'b1;
    end
    if (acc) m_ptr[m_cur] = (m_ptr[m_cur] + (m_wide ? 2 : 1)) % 64;
    m_rdy = rdy_n;
    if (sel_we) begin
      m_cur   = int'(sel_pipe);
      m_valid = 1'b1;
      if (sel_rewind) m_ptr[m_cur] = 0;
      m_force[m_cur] = 1'b0;
      m_wide  = sel_wide;
      m_cdir  = sel_dir;
    end
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic do_sel(int p, bit rew, bit wide, bit dir);
    sel_pipe = 3'(p); sel_rewind = rew; sel_wide = wide; sel_dir = dir;
    sel_we = 1'b1;
    tick();
    sel_we = 1'b0; sel_rewind = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    rst_n = 1'b0;
    sel_we = 0; sel_rewind = 0; sel_wide = 0; sel_dir = 0; sel_pipe = 0;
    cfg_dir = 8'hF0; buf_avail = 8'h00; sbusy = 0; tgl_we = 0;
    rd_en = 0; wr_en = 0; wr_data = 16'h0000;
    m_cur = 0; m_rdy = 0; m_valid = 1; m_wide = 0; m_cdir = 0; m_irq = 0;
    for (int i = 0; i < 8; i++) begin m_ptr[i] = 0; m_force[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk(u0_rdy == 1'b0, "R11", "rdy", 32'(u0_rdy), 0);
    chk(u0_irq == 8'h00, "R11", "brdy_irq", 32'(u0_irq), 0);
    chk(u0_addr == 9'd0, "R11", "mem_addr", 32'(u0_addr), 0);
    chk(u0_be == 2'b01, "R11", "mem_be", 32'(u0_be), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // R1/R5: byte reads from pipe 1, with a read attempted in the gap (R2)
    buf_avail = 8'hFF;
    do_sel(1, 1, 0, 0);
    rd_en = 1'b1;
    tick();
    chk(u0_rdy == 1'b1, "R2", "rdy after gap", 32'(u0_rdy), 1);
    repeat (5) tick();
    rd_en = 1'b0;
    chk(u0_addr == 9'd69, "R5", "byte step", 32'(u0_addr), 69);
    wr_en = 1'b1; tick(); wr_en = 1'b0;   // R6: write on a read pipe

    // R6/R5: halfword writes on pipe 4
    do_sel(4, 1, 1, 0);
    tick();
    wr_en = 1'b1;
    for (int i = 0; i < 3; i++) begin wr_data = 16'hA500 + 16'(i); tick(); end
    wr_en = 1'b0;
    rd_en = 1'b1; tick(); rd_en = 1'b0;   // R6: read on a write pipe

    // R4: resume pipe 1 where it stopped
    do_sel(1, 0, 0, 0);
    chk(u0_addr == 9'd69, "R4", "resume pointer", 32'(u0_addr), 69);
    // R3: rewind pipe 4
    do_sel(4, 1, 1, 0);
    chk(u0_addr == 9'd256, "R3", "rewind pointer", 32'(u0_addr), 256);

    // R5: wrap on pipe 2
    do_sel(2, 1, 1, 0);
    tick();
    rd_en = 1'b1;
    repeat (32) tick();
    rd_en = 1'b0;
    chk(u0_addr == 9'd128, "R5", "wrap", 32'(u0_addr), 128);

    // R8/R9/R10: hand-over of pipe 3
    buf_avail = 8'hF7;
    do_sel(3, 1, 0, 0);
    tick();
    chk(u0_rdy == 1'b0, "R2", "rdy without buffer", 32'(u0_rdy), 0);
    sbusy = 1'b1; tgl_we = 1'b1; tick(); tgl_we = 1'b0;
    chk(u0_irq == 8'h00, "R10", "toggle while busy", 32'(u0_irq), 0);
    sbusy = 1'b0; tgl_we = 1'b1; tick(); tgl_we = 1'b0;
    chk(u0_irq == 8'h08, "R9", "toggle irq", 32'(u0_irq), 8);
    tick();
    chk(u0_rdy == 1'b1, "R8", "rdy after toggle", 32'(u0_rdy), 1);
    chk(u0_irq == 8'h00, "R9", "irq one cycle", 32'(u0_irq), 0);
    tgl_we = 1'b1; tick(); tgl_we = 1'b0;
    chk(u0_irq == 8'h00, "R10", "toggle while ready", 32'(u0_irq), 0);
    rd_en = 1'b1; repeat (2) tick(); rd_en = 1'b0;
    do_sel(3, 0, 0, 0);
    tick();
    chk(u0_rdy == 1'b0, "R8", "hand-over cleared", 32'(u0_rdy), 0);

    // R10: toggle on a write pipe
    buf_avail = 8'hDF;
    do_sel(5, 1, 0, 0);
    tick();
    tgl_we = 1'b1; tick(); tgl_we = 1'b0;
    chk(u0_irq == 8'h00, "R10", "toggle on write pipe", 32'(u0_irq), 0);
    tick();
    chk(u0_rdy == 1'b0, "R10", "no hand-over on write pipe", 32'(u0_rdy), 0);

    // R6: control pipe direction from the select write
    buf_avail = 8'hFF;
    do_sel(0, 1, 0, 1);
    tick();
    wr_en = 1'b1; wr_data = 16'h1234; repeat (2) tick(); wr_en = 1'b0;
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    do_sel(0, 0, 1, 0);
    tick();
    rd_en = 1'b1; repeat (2) tick(); rd_en = 1'b0;

    // R7: DMA-side port refuses the control pipe
    do_sel(0, 1, 0, 0);
    tick();
    chk(u1_rdy == 1'b0, "R7", "dma rdy on pipe 0", 32'(u1_rdy), 0);
    chk(u0_rdy == 1'b1, "R7", "cpu rdy on pipe 0", 32'(u0_rdy), 1);
    do_sel(2, 0, 0, 0);
    tick();
    chk(u1_rdy == 1'b1, "R7", "dma rdy on pipe 2", 32'(u1_rdy), 1);

    // mixed traffic against the reference
    seed = 32'h1357;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 1103515245 + 12345;
      sel_we     = ((seed >>> 16) & 15) == 0;
      sel_pipe   = 3'(seed >>> 8);
      sel_rewind = seed[20];
      sel_wide   = seed[21];
      sel_dir    = seed[22];
      rd_en      = seed[23];
      wr_en      = seed[24];
      wr_data    = 16'(seed >>> 4);
      tgl_we     = ((seed >>> 25) & 7) == 0;
      sbusy      = seed[28];
      if (((seed >>> 12) & 7) == 0) buf_avail[(seed >>> 29) & 7] = ~buf_avail[(seed >>> 29) & 7];
      tick();
    end
    sel_we = 0; rd_en = 0; wr_en = 0; tgl_we = 0;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule